// File: doc/BRIEF.md
# External Interrupt Pin Qualifier

This block sits between four external interrupt pins and the interrupt source multiplexer. Each raw pin is captured in an input register on the rising clock edge. It then passes through a per-pin programmable inversion, so that either a rising or a falling edge at the pin can be used as the trigger. A pin produces an event only when its pulse has a valid shape. The adjusted level must be inactive for at least a minimum number of consecutive samples and then active for at least a minimum number of consecutive samples. Both minimums default to two.

When the shape is met, the pin's event output pulses high for exactly one clock cycle, one cycle after the second active sample is latched. Narrow glitches and pins held at one level produce nothing.

A small configuration port writes and reads the trigger polarity register. When a pin's polarity bit changes, that pin's run history is cleared. The change of polarity therefore never counts as an edge. The polarity only conditions the interrupt path of this block.

Top module: `ext_irq_qualifier`

## Requirements
- R1: After reset the polarity register reads 0 and no event output is high while the pins stay low.
- R2: With polarity bit 0, a pin sampled low on at least 2 consecutive rising edges and then high on 2 consecutive edges k and k+1 drives its event output high for exactly the clock cycle that follows edge k+2. A low run of exactly 2 samples followed by a high run of exactly 2 samples qualifies.
- R3: An inactive run of only 1 sample before the active run produces no event.
- R4: An active run of only 1 sample produces no event.
- R5: One qualifying transition yields exactly one event, one cycle wide, however long the pin then stays active.
- R6: With polarity bit 1 the pin is inverted before qualification: a high-to-low transition with the same run lengths produces the event, and a low-to-high transition produces none.
- R7: Writing the configuration port sets polarity bit i (write data bit i, i = 0..3) for pin i. Bits 31:4 are reserved: they read as 0, and writing them has no effect on the polarity or on qualification.
- R8: When a pin's polarity bit changes value, that pin's run history is cleared. The resulting flip of the adjusted level alone produces no event. A write that leaves the bit unchanged does not clear the history.
- R9: The four pins are qualified independently. Pins that qualify on the same edges raise their events in the same cycle, and a glitch on one pin does not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 4 | Raw external interrupt pins, bit i is pin i |
| cfg_wr_en | input | 1 | Write strobe for the polarity register |
| cfg_wr_data | input | 32 | Write data; bit i is the polarity of pin i, upper bits reserved |
| cfg_rd_data | output | 32 | Polarity register readback, reserved bits zero |
| irq_event | output | 4 | One-cycle recognised event per pin |

## Verification
The bench pins down the exact cycle of the event pulse after the second active sample. A design with one register too many or too few shifts that pulse and fails the check. It drives runs of exactly the minimum length and runs one sample short: a filter with an off-by-one counter either drops the legal 2-low/2-high pulse or lets the single-cycle low or high through. It flips a polarity bit on a pin resting at a long inactive level. A design that keeps the old history then fires a spurious event on the write. A design that forgets the inversion fires on the wrong edge. Reserved-bit writes followed by a legal pulse expose any decode that leaks into the polarity or clears history.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Width of the run-length counters; limits must stay below 2**CNT_W.
  localparam int CNT_W = 4;

  typedef logic [CNT_W-1:0] run_cnt_t;

  // Level after the per-pin trigger inversion: 1 means "active".
  function automatic logic active_level(input logic raw, input logic invert);
    return raw ^ invert;
  endfunction

  // Saturating increment of a run counter.
  function automatic run_cnt_t sat_inc(input run_cnt_t v, input run_cnt_t lim);
    return (v >= lim) ? lim : v + run_cnt_t'(1);
  endfunction

  // The last active sample needed is being seen now and the inactive run before it was long enough.
  function automatic logic qualifies(input logic lvl, input run_cnt_t low_cnt,
                                     input run_cnt_t hi_cnt, input run_cnt_t low_lim,
                                     input run_cnt_t hi_lim);
    return lvl && (hi_cnt == hi_lim - run_cnt_t'(1)) && (low_cnt >= low_lim);
  endfunction

endpackage

// File: rtl/eiq_pol_reg.sv
module eiq_pol_reg #(
  parameter int NUM_PINS = 4,
  parameter int REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [NUM_PINS-1:0] pol_o,
  output logic [NUM_PINS-1:0] clr_o,
  output logic [REG_W-1:0]    rd_data_o
);

  localparam logic [REG_W-1:0] PIN_MASK = REG_W'((64'd1 << NUM_PINS) - 64'd1);

  logic [REG_W-1:0] pol_q;

  // R7: only the pin bits are stored, reserved bits stay zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else if (wr_en) pol_q <= wr_data & PIN_MASK;
  end

  // R8: per-pin history clear, raised only when the bit actually changes.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    assign pol_o[i] = pol_q[i];
    assign clr_o[i] = wr_en & (wr_data[i] ^ pol_q[i]);
  end

  assign rd_data_o = pol_q;

  // R7: the polarity only moves on a write.
  assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pol_q));

  // R8: a clear is only ever requested by a write.
  assert_clear_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_o) |-> wr_en);

endmodule

// File: rtl/eiq_pin_qual.sv
module eiq_pin_qual
  import ext_irq_pkg::*;
#(
  parameter int MIN_LOW  = 2,
  parameter int MIN_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  input  logic hist_clr_i,
  output logic event_o
);

  localparam run_cnt_t LOW_LIM = run_cnt_t'(MIN_LOW);
  localparam run_cnt_t HI_LIM  = run_cnt_t'(MIN_HIGH);

  logic     in_q;     // input register: the latched pin
  logic     lvl;      // polarity-adjusted latched level
  run_cnt_t low_cnt;  // inactive run before the current active run
  run_cnt_t hi_cnt;   // current active run
  logic     fire;     // qualifying sample seen this cycle
  logic     evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_q <= 1'b0;
    else        in_q <= pin_i;
  end

  assign lvl  = active_level(in_q, pol_i);
  assign fire = qualifies(lvl, low_cnt, hi_cnt, LOW_LIM, HI_LIM);

  // Run-length tracking. low_cnt is held during an active run so the
  // qualification can look back at the run that preceded it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else if (hist_clr_i) begin
      low_cnt <= '0;
      hi_cnt  <= '0;
    end else if (lvl) begin
      hi_cnt  <= sat_inc(hi_cnt, HI_LIM);
    end else begin
      hi_cnt  <= '0;
      low_cnt <= (hi_cnt != '0) ? run_cnt_t'(1) : sat_inc(low_cnt, LOW_LIM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= fire & ~hist_clr_i;
  end

  assign event_o = evt_q;

  // R5: each event lasts one cycle.
  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);

  // R2: an event is preceded by two active and, before them, two inactive latched samples.
  assert_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_q) |-> ($past(lvl, 1) && $past(lvl, 2) && !$past(lvl, 3) && !$past(lvl, 4)));

  // R8: a polarity change cannot qualify on the following cycle.
  assert_clear_no_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr_i |=> !fire);

  // R3: a qualifying sample always sits on an active level with a completed inactive run.
  assert_low_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (lvl && $past(low_cnt) != '0));

endmodule

// File: rtl/ext_irq_qualifier.sv
module ext_irq_qualifier #(
  parameter int NUM_PINS = 4,
  parameter int REG_W    = 32,
  parameter int MIN_LOW  = 2,
  parameter int MIN_HIGH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic                cfg_wr_en,
  input  logic [REG_W-1:0]    cfg_wr_data,
  output logic [REG_W-1:0]    cfg_rd_data,
  output logic [NUM_PINS-1:0] irq_event
);

  logic [NUM_PINS-1:0] pol;
  logic [NUM_PINS-1:0] hist_clr;

  eiq_pol_reg #(
    .NUM_PINS (NUM_PINS),
    .REG_W    (REG_W)
  ) u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .pol_o     (pol),
    .clr_o     (hist_clr),
    .rd_data_o (cfg_rd_data)
  );

  // R9: one independent qualifier per pin.
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    eiq_pin_qual #(
      .MIN_LOW  (MIN_LOW),
      .MIN_HIGH (MIN_HIGH)
    ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_raw[i]),
      .pol_i      (pol[i]),
      .hist_clr_i (hist_clr[i]),
      .event_o    (irq_event[i])
    );
  end

  // R1: the event outputs are low in the first cycle after reset.
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_event == '0));

endmodule

// File: tb/ext_irq_qualifier_tb.sv
module ext_irq_qualifier_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_raw = '0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic [3:0]  irq_event;

  int n_checks = 0;
  int n_err = 0;
  int ev_cnt [NP];
  int wide_cnt = 0;
  logic [3:0] ev_prev = '0;
  bit done = 0;

  ext_irq_qualifier u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_raw     (pin_raw),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_data (cfg_rd_data),
    .irq_event   (irq_event)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Event monitor: counts pulses and pulses wider than one cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NP; i++) begin
        if (irq_event[i]) ev_cnt[i] = ev_cnt[i] + 1;
        if (irq_event[i] && ev_prev[i]) wide_cnt = wide_cnt + 1;
      end
      ev_prev = irq_event;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < NP; i++) ev_cnt[i] = 0;
    wide_cnt = 0;
  endtask

  task automatic write_pol(input logic [31:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    cyc(1);
    cfg_wr_en = 1'b0;
    cfg_wr_data = '0;
  endtask

  task automatic print_summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
  endtask

  task automatic t_reset_R1();
    cyc(6);
    check_eq("R1 readback", int'(cfg_rd_data), 0);
    check_eq("R1 events", int'(irq_event), 0);
    check_eq("R1 event count", ev_cnt[0] + ev_cnt[1] + ev_cnt[2] + ev_cnt[3], 0);
  endtask

  task automatic t_rise_timing_R2();
    clear_counts();
    pin_raw[0] = 1'b1;
    cyc(1); check_eq("R2 no event after edge k", int'(irq_event[0]), 0);
    cyc(1); check_eq("R2 no event after edge k+1", int'(irq_event[0]), 0);
    cyc(1); check_eq("R2 event after edge k+2", int'(irq_event[0]), 1);
    cyc(1); check_eq("R2 event gone after edge k+3", int'(irq_event[0]), 0);
    cyc(20);
    check_eq("R5 one event while held high", ev_cnt[0], 1);
    check_eq("R5 no wide pulse", wide_cnt, 0);
    check_eq("R9 other pins quiet", ev_cnt[1] + ev_cnt[2] + ev_cnt[3], 0);
    pin_raw[0] = 1'b0;
    cyc(4);
  endtask

  task automatic t_boundary_R2();
    pin_raw[1] = 1'b1; cyc(6);
    clear_counts();
    pin_raw[1] = 1'b0; cyc(2);
    pin_raw[1] = 1'b1; cyc(2);
    pin_raw[1] = 1'b0; cyc(5);
    check_eq("R2 exact 2-low 2-high pulse", ev_cnt[1], 1);
  endtask

  task automatic t_short_low_R3();
    pin_raw[2] = 1'b1; cyc(6);
    clear_counts();
    pin_raw[2] = 1'b0; cyc(1);
    pin_raw[2] = 1'b1; cyc(6);
    check_eq("R3 one-sample low ignored", ev_cnt[2], 0);
    pin_raw[2] = 1'b0; cyc(4);
  endtask

  task automatic t_short_high_R4();
    clear_counts();
    pin_raw[3] = 1'b1; cyc(1);
    pin_raw[3] = 1'b0; cyc(6);
    check_eq("R4 one-sample high ignored", ev_cnt[3], 0);
  endtask

  task automatic t_falling_R6();
    pin_raw[0] = 1'b1; cyc(6);
    write_pol(32'h1);
    cyc(4);
    clear_counts();
    pin_raw[0] = 1'b0;
    cyc(2); check_eq("R6 no early event", int'(irq_event[0]), 0);
    cyc(1); check_eq("R6 falling edge event", int'(irq_event[0]), 1);
    cyc(4);
    pin_raw[0] = 1'b1; cyc(6);
    check_eq("R6 rising edge ignored when inverted", ev_cnt[0], 1);
    write_pol(32'h0);
    pin_raw[0] = 1'b0; cyc(6);
  endtask

  task automatic t_readback_R7();
    write_pol(32'hFFFF_FFFA);
    check_eq("R7 reserved bits read zero", int'(cfg_rd_data), 32'hA);
    write_pol(32'h0);
    check_eq("R7 cleared", int'(cfg_rd_data), 0);
    cyc(6);
    clear_counts();
    write_pol(32'hFFFF_FFF0);
    check_eq("R7 reserved write keeps polarity", int'(cfg_rd_data), 0);
    pin_raw[1] = 1'b1; cyc(5);
    check_eq("R7 reserved write keeps history", ev_cnt[1], 1);
    pin_raw[1] = 1'b0; cyc(4);
  endtask

  task automatic t_pol_change_R8();
    clear_counts();
    write_pol(32'h4);
    cyc(8);
    check_eq("R8 0->1 change on low pin no event", ev_cnt[2], 0);
    pin_raw[2] = 1'b1; cyc(6);
    write_pol(32'h0);
    cyc(8);
    check_eq("R8 1->0 change on high pin no event", ev_cnt[2], 0);
    pin_raw[2] = 1'b0; cyc(6);
  endtask

  task automatic t_parallel_R9();
    clear_counts();
    pin_raw = 4'hF;
    cyc(3);
    check_eq("R9 all events together", int'(irq_event), 15);
    pin_raw = 4'h0; cyc(4);
    clear_counts();
    pin_raw = 4'b0011; cyc(1);
    pin_raw = 4'b0001; cyc(2);
    check_eq("R9 only valid pin fires", int'(irq_event), 1);
    cyc(4);
    check_eq("R9 glitch pin count", ev_cnt[1], 0);
    pin_raw = 4'h0; cyc(4);
  endtask

  initial begin
    clear_counts();
    cyc(3);
    rst_n = 1'b1;
    t_reset_R1();
    t_rise_timing_R2();
    t_boundary_R2();
    t_short_low_R3();
    t_short_high_R4();
    t_falling_R6();
    t_readback_R7();
    t_pol_change_R8();
    t_parallel_R9();
    if (!done) begin
      done = 1;
      print_summary();
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      print_summary();
      $finish;
    end
  end

endmodule